// File: doc/BRIEF.md
# Routed Shared Interrupt Aggregator

This block collects a parameterised number of external interrupt sources and steers each one onto a single interrupt line of a single processor. Every source carries four pieces of state: an enable, a pending flag, a destination pin number with a separate map-to-pin flag, and a destination processor that may be left unrouted. For every (processor, pin) pair there is one level output. That output is high while at least one source routed to the pair is both enabled and pending.

Software configures the block over a simple register bus with read and write strobes, an address, a byte-size code and a data word. Enables never change through a plain write. One bank of registers sets enables and another clears them, and only the data bits written as 1 have any effect. A trigger register lets software force the pending level of any source. Hardware inputs are level signals sampled on every clock. A change in a hardware input is copied into the pending flag whether or not the source is enabled.

Top module: `irq_route_agg`

## Requirements
- R1: After reset every source is disabled and not pending. The pin map of every source reads 0x8000_0000 (only the map-to-pin flag, bit 31, set). The processor map of every source reads 0. All outputs are low.
- R2: A write to the set bank (byte offsets 0x040–0x05F) enables source `8*(addr-0x040)+i` for each data bit i that is 1. Data bits that are 0 leave their sources as they are.
- R3: A write to the clear bank (byte offsets 0x060–0x07F) disables source `8*(addr-0x060)+i` for each data bit i that is 1. Data bits that are 0 leave their sources as they are.
- R4: Reading the pending bank (0x000–0x01F) or the enable bank (0x020–0x03F) returns one bit per source, in the same byte×8+i order, across the access width. The size code sets the width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. A bank access that would reach past the last source is ignored, and so is size code 3. Such a read returns zero.
- R5: The pin map of source n sits at 0x400+4n. It holds the pin number in bits [5:0] and the map-to-pin flag in bit 31. A write whose pin number exceeds MAX_PIN is discarded.
- R6: The processor map of source n sits at 0x800+4n. A write with data selects the processor given by the lowest set bit of that data. A write of zero makes the source unrouted. A write whose lowest set bit is not below NUM_PROC is discarded. A read returns a single 1 at the selected processor's bit position, or 0 when the source is unrouted.
- R7: A write to the trigger register (0x080) sets the pending flag of source `wdata[30:0]` to `wdata[31]`. An index of NUM_SRC or above leaves every pending flag unchanged.
- R8: A change on `irq_in[n]` copies the new level into the pending flag of source n. This happens regardless of whether the source is enabled.
- R9: Output bit `p*(MAX_PIN+1)+k` is the OR of all sources that are enabled, pending, routed to processor p and mapped to pin k. Disabled or unrouted sources contribute nothing. The output follows the clock edge that registers the causing write or input change.
- R10: A trigger write and a hardware input change can hit the same source in the same cycle. When they do, the pending flag takes the trigger's level.
- R11: `rd_data` carries the value one clock after `rd_en` is accepted. It is zero in cycles without a read and for unmapped addresses (0xC00 and up, or unused words).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_SRC | Hardware interrupt levels, one per source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address |
| size | input | 2 | Access size code (0: 1 byte, 1: 2 bytes, 2: 4 bytes) |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_out | output | NUM_PROC*(MAX_PIN+1) | Level output per processor and pin |

## Verification
The interesting collision is a software trigger write and a hardware level change landing on the same source in one cycle. Both try to update that source's pending flag. The bench provokes this by raising `irq_in` and presenting a trigger write with the opposite level on the same negative edge. It then repeats the stimulus with both levels inverted. In each case it judges the winner by reading the pending bank and watching the routed output: the pending flag must follow the trigger's level. A second coincidence is also checked. When an enable is written while a source is already pending, the output must rise on that same edge.

// File: rtl/ira_pkg.sv
// Package ira_pkg
// Shared constants and helpers for the routed interrupt aggregator.
// It fixes the register address windows, the field positions and the bank-fit rule.
// Assumes a 12-bit byte address and a 32-bit data bus.
package ira_pkg;
    localparam int ADDR_W       = 12;
    localparam int DATA_W       = 32;
    localparam int PIN_FIELD_W  = 6;
    localparam int PIN_FLAG_BIT = 31;
    localparam int TRIG_LVL_BIT = 31;

    // 32-byte bank windows, selected by addr[11:5]
    localparam logic [6:0] WIN_PEND = 7'd0;
    localparam logic [6:0] WIN_MASK = 7'd1;
    localparam logic [6:0] WIN_SET  = 7'd2;
    localparam logic [6:0] WIN_CLR  = 7'd3;

    localparam logic [ADDR_W-1:0] OFS_TRIG = 12'h080;

    // 1 KiB map segments, selected by addr[11:10]
    localparam logic [1:0] SEG_PIN  = 2'd1;
    localparam logic [1:0] SEG_PROC = 2'd2;

    // True when a bank access of this size at this byte offset stays inside num_src
    function automatic logic bank_fits(input logic [4:0] byte_off, input logic [1:0] size,
                                       input int num_src);
        int base;
        int nbits;
        base  = int'(byte_off) * 8;
        nbits = 8 << size;
        return (size != 2'd3) && (base + nbits <= num_src);
    endfunction

    // Index of the lowest set bit, or DATA_W when the word is zero
    function automatic logic [5:0] lowest_set(input logic [DATA_W-1:0] v);
        logic [5:0] r;
        r = 6'd32;
        for (int b = DATA_W - 1; b >= 0; b--) begin
            if (v[b]) r = 6'(b);
        end
        return r;
    endfunction

    // Byte-lane mask for a size code
    function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] size);
        case (size)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/ira_src_bank.sv
// Module ira_src_bank
// Holds the per-source state (enable, pending, pin map, processor map).
// It decodes every write that changes that state.
// Assumes that IDX_W equals clog2(NUM_SRC) and that PROC_W is wide enough for NUM_PROC-1.
module ira_src_bank
    import ira_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_PROC = 4,
    parameter int MAX_PIN  = 5,
    parameter int PROC_W   = 2,
    parameter int IDX_W    = 5
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_SRC-1:0]                  irq_in,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [1:0]                          size,
    input  logic [DATA_W-1:0]                   wdata,
    output logic [NUM_SRC-1:0]                  src_en,
    output logic [NUM_SRC-1:0]                  src_pend,
    output logic [NUM_SRC-1:0]                  src_routed,
    output logic [NUM_SRC-1:0]                  src_pflag,
    output logic [NUM_SRC-1:0][PIN_FIELD_W-1:0] src_pin,
    output logic [NUM_SRC-1:0][PROC_W-1:0]      src_proc
);
    localparam int SPAN = NUM_SRC + DATA_W;

    logic [NUM_SRC-1:0] irq_q;
    logic [NUM_SRC-1:0] bank_bits;
    logic [SPAN-1:0]    spread;
    logic [7:0]         base;
    logic               bank_ok, set_hit, clr_hit, trig_hit;
    logic               map_ok, pin_hit, proc_hit, proc_clear;
    logic [IDX_W-1:0]   map_idx, trig_idx;
    logic [5:0]         proc_low;

    // Decode the write strobe into one hit per register kind
    always_comb begin : write_decode
        bank_ok    = bank_fits(addr[4:0], size, NUM_SRC);
        set_hit    = wr_en && bank_ok && (addr[ADDR_W-1:5] == WIN_SET);
        clr_hit    = wr_en && bank_ok && (addr[ADDR_W-1:5] == WIN_CLR);
        trig_hit   = wr_en && (addr == OFS_TRIG) && (int'(wdata[30:0]) < NUM_SRC);
        trig_idx   = wdata[IDX_W-1:0];
        map_ok     = (addr[1:0] == 2'd0) && (int'(addr[9:2]) < NUM_SRC);
        map_idx    = addr[IDX_W+1:2];
        pin_hit    = wr_en && map_ok && (addr[11:10] == SEG_PIN) &&
                     (int'(wdata[PIN_FIELD_W-1:0]) <= MAX_PIN);
        proc_low   = lowest_set(wdata);
        proc_clear = wr_en && map_ok && (addr[11:10] == SEG_PROC) && (wdata == '0);
        proc_hit   = wr_en && map_ok && (addr[11:10] == SEG_PROC) && (wdata != '0) &&
                     (int'(proc_low) < NUM_PROC);
    end

    // Spread the written lanes onto source positions
    always_comb begin : bank_spread
        base      = {addr[4:0], 3'b000};
        spread    = SPAN'(wdata & lane_mask(size)) << base;
        bank_bits = spread[NUM_SRC-1:0];
    end

    // Per-source state registers; the trigger write wins over a hardware change
    always_ff @(posedge clk) begin : state_regs
        if (!rst_n) begin
            src_en     <= '0;
            src_pend   <= '0;
            irq_q      <= '0;
            src_routed <= '0;
            src_pflag  <= '1;
            src_pin    <= '0;
            src_proc   <= '0;
        end else begin
            irq_q <= irq_in;
            if (set_hit) begin
                src_en <= src_en | bank_bits;
            end else if (clr_hit) begin
                src_en <= src_en & ~bank_bits;
            end
            for (int i = 0; i < NUM_SRC; i++) begin
                if (trig_hit && (int'(trig_idx) == i)) begin
                    src_pend[i] <= wdata[TRIG_LVL_BIT];
                end else if (irq_in[i] != irq_q[i]) begin
                    src_pend[i] <= irq_in[i];
                end
            end
            if (pin_hit) begin
                src_pin[map_idx]   <= wdata[PIN_FIELD_W-1:0];
                src_pflag[map_idx] <= wdata[PIN_FLAG_BIT];
            end
            if (proc_hit) begin
                src_routed[map_idx] <= 1'b1;
                src_proc[map_idx]   <= proc_low[PROC_W-1:0];
            end else if (proc_clear) begin
                src_routed[map_idx] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ira_route_or.sv
// Module ira_route_or
// Builds one OR tree per (processor, pin) pair over the sources that are enabled,
// pending and routed to that pair.
// Assumes that the inputs come straight from registers, so the outputs follow the state edge.
module ira_route_or
    import ira_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_PROC = 4,
    parameter int MAX_PIN  = 5,
    parameter int PROC_W   = 2
) (
    input  logic [NUM_SRC-1:0]                  src_en,
    input  logic [NUM_SRC-1:0]                  src_pend,
    input  logic [NUM_SRC-1:0]                  src_routed,
    input  logic [NUM_SRC-1:0][PIN_FIELD_W-1:0] src_pin,
    input  logic [NUM_SRC-1:0][PROC_W-1:0]      src_proc,
    output logic [NUM_PROC*(MAX_PIN+1)-1:0]     irq_out
);
    localparam int NUM_PIN = MAX_PIN + 1;

    logic [NUM_SRC-1:0] live;

    // Sources that may drive any output at all
    always_comb begin : live_sources
        live = src_en & src_pend & src_routed;
    end

    for (genvar p = 0; p < NUM_PROC; p++) begin : g_proc
        for (genvar k = 0; k < NUM_PIN; k++) begin : g_pin
            logic [NUM_SRC-1:0] hit;
            // Select the live sources that target this processor and pin
            always_comb begin : pair_select
                for (int i = 0; i < NUM_SRC; i++) begin
                    hit[i] = live[i] && (int'(src_proc[i]) == p) && (int'(src_pin[i]) == k);
                end
            end
            assign irq_out[p*NUM_PIN + k] = |hit;
        end
    end
endmodule

// File: rtl/ira_read_mux.sv
// Module ira_read_mux
// Selects the read value for the addressed register and registers it for one cycle.
// Assumes that rd_data is zero in any cycle without an accepted read.
module ira_read_mux
    import ira_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int PROC_W  = 2,
    parameter int IDX_W   = 5
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                rd_en,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [1:0]                          size,
    input  logic [NUM_SRC-1:0]                  src_en,
    input  logic [NUM_SRC-1:0]                  src_pend,
    input  logic [NUM_SRC-1:0]                  src_routed,
    input  logic [NUM_SRC-1:0]                  src_pflag,
    input  logic [NUM_SRC-1:0][PIN_FIELD_W-1:0] src_pin,
    input  logic [NUM_SRC-1:0][PROC_W-1:0]      src_proc,
    output logic [DATA_W-1:0]                   rd_data
);
    localparam int SPAN = NUM_SRC + DATA_W;

    logic [SPAN-1:0]   pend_sh, en_sh;
    logic [7:0]        base;
    logic              bank_ok, map_ok;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rd_next;

    // Form the value of the addressed register
    always_comb begin : read_select
        base    = {addr[4:0], 3'b000};
        pend_sh = SPAN'(src_pend) >> base;
        en_sh   = SPAN'(src_en) >> base;
        bank_ok = bank_fits(addr[4:0], size, NUM_SRC);
        map_ok  = (addr[1:0] == 2'd0) && (int'(addr[9:2]) < NUM_SRC);
        idx     = addr[IDX_W+1:2];
        rd_next = '0;
        if (bank_ok && (addr[ADDR_W-1:5] == WIN_PEND)) begin
            rd_next = pend_sh[DATA_W-1:0] & lane_mask(size);
        end else if (bank_ok && (addr[ADDR_W-1:5] == WIN_MASK)) begin
            rd_next = en_sh[DATA_W-1:0] & lane_mask(size);
        end else if (map_ok && (addr[11:10] == SEG_PIN)) begin
            rd_next[PIN_FLAG_BIT]      = src_pflag[idx];
            rd_next[PIN_FIELD_W-1:0]   = src_pin[idx];
        end else if (map_ok && (addr[11:10] == SEG_PROC) && src_routed[idx]) begin
            rd_next = DATA_W'(1) << src_proc[idx];
        end
    end

    // Register the read value; zero when no read is accepted
    always_ff @(posedge clk) begin : read_reg
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_en ? rd_next : '0;
        end
    end
endmodule

// File: rtl/irq_route_agg.sv
// Module irq_route_agg
// Top of the routed shared interrupt aggregator: source state, output OR trees
// and the register read path.
// Assumes that NUM_SRC is a multiple of 8 in 8..256, that NUM_PROC is in 1..32 and that MAX_PIN is at most 63.
module irq_route_agg
    import ira_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_PROC = 4,
    parameter int MAX_PIN  = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SRC-1:0]              irq_in,
    input  logic                            wr_en,
    input  logic                            rd_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [1:0]                      size,
    input  logic [DATA_W-1:0]               wdata,
    output logic [DATA_W-1:0]               rd_data,
    output logic [NUM_PROC*(MAX_PIN+1)-1:0] irq_out
);
    localparam int PROC_W = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1;
    localparam int IDX_W  = $clog2(NUM_SRC);

    if ((NUM_SRC % 8) != 0 || NUM_SRC < 8 || NUM_SRC > 256) begin : g_bad_src
        $error("NUM_SRC must be a nonzero multiple of 8 no larger than 256");
    end
    if (NUM_PROC < 1 || NUM_PROC > DATA_W) begin : g_bad_proc
        $error("NUM_PROC must lie in 1..32");
    end
    if (MAX_PIN < 0 || MAX_PIN >= (1 << PIN_FIELD_W)) begin : g_bad_pin
        $error("MAX_PIN must fit the pin field");
    end

    logic [NUM_SRC-1:0]                  src_en, src_pend, src_routed, src_pflag;
    logic [NUM_SRC-1:0][PIN_FIELD_W-1:0] src_pin;
    logic [NUM_SRC-1:0][PROC_W-1:0]      src_proc;

    ira_src_bank #(
        .NUM_SRC(NUM_SRC), .NUM_PROC(NUM_PROC), .MAX_PIN(MAX_PIN),
        .PROC_W(PROC_W), .IDX_W(IDX_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .wr_en(wr_en), .addr(addr), .size(size), .wdata(wdata),
        .src_en(src_en), .src_pend(src_pend), .src_routed(src_routed),
        .src_pflag(src_pflag), .src_pin(src_pin), .src_proc(src_proc)
    );

    ira_route_or #(
        .NUM_SRC(NUM_SRC), .NUM_PROC(NUM_PROC), .MAX_PIN(MAX_PIN), .PROC_W(PROC_W)
    ) u_route (
        .src_en(src_en), .src_pend(src_pend), .src_routed(src_routed),
        .src_pin(src_pin), .src_proc(src_proc), .irq_out(irq_out)
    );

    ira_read_mux #(
        .NUM_SRC(NUM_SRC), .PROC_W(PROC_W), .IDX_W(IDX_W)
    ) u_read (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .size(size),
        .src_en(src_en), .src_pend(src_pend), .src_routed(src_routed),
        .src_pflag(src_pflag), .src_pin(src_pin), .src_proc(src_proc),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/ira_checker.sv
// Module ira_checker
// Property checks for irq_route_agg, attached by bind.
// Assumes that it sees the top ports plus the registered enable and pending vectors.
module ira_checker
    import ira_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_PROC = 4,
    parameter int MAX_PIN  = 5
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic                            rd_en,
    input logic [ADDR_W-1:0]               addr,
    input logic [1:0]                      size,
    input logic [DATA_W-1:0]               wdata,
    input logic [NUM_SRC-1:0]              irq_in,
    input logic [DATA_W-1:0]               rd_data,
    input logic [NUM_PROC*(MAX_PIN+1)-1:0] irq_out,
    input logic [NUM_SRC-1:0]              src_en,
    input logic [NUM_SRC-1:0]              src_pend
);
    logic [NUM_SRC-1:0] irq_prev;

    // Checker copy of the previous hardware levels
    always_ff @(posedge clk) begin : prev_levels
        if (!rst_n) irq_prev <= '0;
        else        irq_prev <= irq_in;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0));

    a_r9_out_needs_live_source: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out != '0) |-> ((src_en & src_pend) != '0));

    a_r7_bad_index_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == OFS_TRIG) && (int'(wdata[30:0]) >= NUM_SRC) && (irq_in == irq_prev))
        |=> $stable(src_pend));

    a_r4_overrun_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr[ADDR_W-1:6] == 6'd0) && !bank_fits(addr[4:0], size, NUM_SRC))
        |=> (rd_data == '0));

    a_r11_idle_or_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || (addr[11:10] == 2'd3)) |=> (rd_data == '0));
endmodule

bind irq_route_agg ira_checker #(
    .NUM_SRC(NUM_SRC), .NUM_PROC(NUM_PROC), .MAX_PIN(MAX_PIN)
) u_ira_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .size(size), .wdata(wdata), .irq_in(irq_in), .rd_data(rd_data),
    .irq_out(irq_out), .src_en(src_en), .src_pend(src_pend)
);

// File: tb/irq_route_agg_tb_top.sv
`timescale 1ns/1ps
// Directed bench for irq_route_agg: one task per scenario, each checking its own results.
module irq_route_agg_tb_top;
    localparam int NS = 32;
    localparam int NP = 4;
    localparam int MP = 5;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NS-1:0]         irq_in = '0;
    logic                  wr_en = 1'b0;
    logic                  rd_en = 1'b0;
    logic [11:0]           addr = '0;
    logic [1:0]            size = '0;
    logic [31:0]           wdata = '0;
    logic [31:0]           rd_data;
    logic [NP*(MP+1)-1:0]  irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    irq_route_agg #(.NUM_SRC(NS), .NUM_PROC(NP), .MAX_PIN(MP)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .size(size), .wdata(wdata), .rd_data(rd_data), .irq_out(irq_out)
    );

    // 250 MHz clock
    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; size = s; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a; size = s;
        @(negedge clk);
        d = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 outputs low", 32'(irq_out), 32'h0);
        bus_rd(12'h000, 2'd2, v); check("R1 pending clear", v, 32'h0);
        bus_rd(12'h020, 2'd2, v); check("R1 enables clear", v, 32'h0);
        bus_rd(12'h40C, 2'd2, v); check("R1 pin map flag only", v, 32'h8000_0000);
        bus_rd(12'h80C, 2'd2, v); check("R1 unrouted", v, 32'h0);
    endtask

    task automatic t_mask_banks();
        logic [31:0] v;
        bus_wr(12'h040, 2'd2, 32'h0000_00A5);
        bus_rd(12'h020, 2'd2, v); check("R2 set word", v, 32'h0000_00A5);
        bus_wr(12'h041, 2'd0, 32'h0000_0003);
        bus_rd(12'h020, 2'd2, v); check("R2 set byte 1 keeps others", v, 32'h0000_03A5);
        bus_wr(12'h060, 2'd0, 32'h0000_0081);
        bus_rd(12'h020, 2'd2, v); check("R3 clear byte", v, 32'h0000_0324);
        bus_rd(12'h021, 2'd1, v); check("R4 halfword read", v, 32'h0000_0003);
        bus_rd(12'h022, 2'd2, v); check("R4 overrun read zero", v, 32'h0);
        bus_wr(12'h043, 2'd1, 32'h0000_FFFF);
        bus_wr(12'h040, 2'd3, 32'hFFFF_FFFF);
        bus_rd(12'h020, 2'd2, v); check("R4 overrun and bad size write ignored", v, 32'h0000_0324);
        bus_rd(12'h023, 2'd0, v); check("R4 last byte fits", v, 32'h0);
    endtask

    task automatic t_pin_map();
        logic [31:0] v;
        bus_wr(12'h404, 2'd2, 32'h8000_0003);
        bus_rd(12'h404, 2'd2, v); check("R5 pin and flag", v, 32'h8000_0003);
        bus_wr(12'h404, 2'd2, 32'h0000_0006);
        bus_rd(12'h404, 2'd2, v); check("R5 pin above max discarded", v, 32'h8000_0003);
        bus_wr(12'h404, 2'd2, 32'h0000_0002);
        bus_rd(12'h404, 2'd2, v); check("R5 pin rewrite", v, 32'h0000_0002);
    endtask

    task automatic t_proc_map();
        logic [31:0] v;
        bus_wr(12'h804, 2'd2, 32'h0000_000C);
        bus_rd(12'h804, 2'd2, v); check("R6 lowest set bit", v, 32'h0000_0004);
        bus_wr(12'h804, 2'd2, 32'h0000_0010);
        bus_rd(12'h804, 2'd2, v); check("R6 processor out of range", v, 32'h0000_0004);
        bus_wr(12'h804, 2'd2, 32'h0);
        bus_rd(12'h804, 2'd2, v); check("R6 zero unroutes", v, 32'h0);
        bus_wr(12'h804, 2'd2, 32'h0000_0008);
        bus_rd(12'h804, 2'd2, v); check("R6 processor 3", v, 32'h0000_0008);
    endtask

    task automatic t_route_trigger();
        logic [31:0] v;
        bus_wr(12'h080, 2'd2, 32'h8000_0001);
        check("R9 disabled source silent", 32'(irq_out), 32'h0);
        bus_rd(12'h000, 2'd2, v); check("R7 trigger sets pending", v, 32'h0000_0002);
        bus_wr(12'h080, 2'd2, 32'h8000_0020);
        bus_rd(12'h000, 2'd2, v); check("R7 bad index ignored", v, 32'h0000_0002);
        bus_wr(12'h040, 2'd0, 32'h0000_0002);
        check("R9 enable raises proc3 pin2", 32'(irq_out), 32'h0010_0000);
        bus_wr(12'h080, 2'd2, 32'h0000_0001);
        check("R9 trigger low drops output", 32'(irq_out), 32'h0);
    endtask

    task automatic t_hw_inputs();
        logic [31:0] v;
        bus_wr(12'h410, 2'd2, 32'h0);
        bus_wr(12'h810, 2'd2, 32'h0000_0001);
        bus_wr(12'h040, 2'd0, 32'h0000_0010);
        @(negedge clk); irq_in[4] = 1'b1;
        @(negedge clk);
        check("R8 hardware level routed", 32'(irq_out), 32'h0000_0001);
        irq_in[6] = 1'b1;
        bus_rd(12'h000, 2'd2, v); check("R8 pending while disabled", v, 32'h0000_0050);
        check("R9 disabled source adds nothing", 32'(irq_out), 32'h0000_0001);
        @(negedge clk); irq_in[4] = 1'b0; irq_in[6] = 1'b0;
        @(negedge clk);
        check("R8 hardware low clears", 32'(irq_out), 32'h0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        @(negedge clk);
        irq_in[4] = 1'b1; wr_en = 1'b1; addr = 12'h080; size = 2'd2; wdata = 32'h0000_0004;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        check("R10 trigger low wins", 32'(irq_out), 32'h0);
        bus_rd(12'h000, 2'd2, v); check("R10 pending stays low", v, 32'h0);
        @(negedge clk);
        irq_in[4] = 1'b0; wr_en = 1'b1; addr = 12'h080; wdata = 32'h8000_0004;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        check("R10 trigger high wins", 32'(irq_out), 32'h0000_0001);
        bus_wr(12'h080, 2'd2, 32'h0000_0004);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        bus_rd(12'hC00, 2'd2, v); check("R11 unmapped zero", v, 32'h0);
        bus_rd(12'h084, 2'd2, v); check("R11 unused word zero", v, 32'h0);
        @(negedge clk);
        check("R11 idle read data zero", rd_data, 32'h0);
    endtask

    initial begin : main_seq
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_banks();
        t_pin_map();
        t_proc_map();
        t_route_trigger();
        t_hw_inputs();
        t_same_cycle();
        t_unmapped();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule